// File: doc/BRIEF.md
# Instruction Address Generator with Return Stack

This block produces the fetch address for a small accumulator-style microcontroller core. It keeps a 13-bit program counter and, on each clock, picks the next value from one of several sources chosen by a 3-bit source code. The sources are: count up by one, load a jump target, call a subroutine, return from one, take an interrupt, or hold. Calls and interrupt entry save a return address on an eight-entry return stack. Returns take the most recent entry back off the stack.

Software may also write the low eight bits of the counter. The upper five bits of the new value then come from a separate page register. That register can only be written; the counter never copies its own upper bits back into it. Only 1K words of program storage exist, so the fetch address is the low ten counter bits, and every 1K page of the 13-bit space maps onto the same words.

Top module: `pc_stack_unit`

## Requirements
- R1: While `rst_n` is low and after its release, the counter and the page register are 0; `pcFull` and `fetchAddr` read 0 until the first clock edge that has reset released.
- R2: Source code 0 (sequential) adds one to the counter at each clock edge. The value 1FFFh is followed by 0000h.
- R3: Source code 1 (jump) loads `jumpTarget` into the counter at the clock edge.
- R4: Source code 2 (call) saves counter+1 on the stack and loads `jumpTarget`. Source code 3 (return) loads the most recently saved entry and removes it. Nested calls return in last-in first-out order.
- R5: Source code 4 (interrupt) saves the current counter value, without the +1, on the stack and loads 0004h.
- R6: The stack is an eight-entry circular buffer with no overflow or underflow indication. A ninth save overwrites the oldest entry. After that, the ninth return yields the ninth saved value again.
- R7: When `lowWrEn` is high, the counter becomes {page register, `lowWrData`}. This takes priority over any source code, and the stack is left untouched in that cycle.
- R8: `pageWrEn` loads `pageWrData` into the 5-bit page register and does nothing else. A page write in the same cycle as a low-byte write does not affect that low-byte write, which uses the old page value. Counter upper bits never reach the page register.
- R9: `fetchAddr` equals the low ten bits of the counter, so addresses 1K apart fetch the same word.
- R10: Source codes 5, 6 and 7 (hold) leave the counter and the stack unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| srcSel | input | 3 | Next-counter source code (0 seq, 1 jump, 2 call, 3 return, 4 interrupt, 5-7 hold) |
| jumpTarget | input | 13 | Target address for jump and call |
| lowWrEn | input | 1 | Software write strobe for the low counter byte |
| lowWrData | input | 8 | Byte written to the low counter bits |
| pageWrEn | input | 1 | Write strobe for the page register |
| pageWrData | input | 5 | Value for the page register |
| pcFull | output | 13 | Full program counter |
| pcLow | output | 8 | Low counter byte as read by software |
| fetchAddr | output | 10 | Physical fetch address |

## Verification
The hardest state to reach is a stack that has wrapped. Getting there takes more than eight saves without returns, and then more than eight returns, so the stale and overwritten entries come back out. The stimulus nests ten calls, unwinds ten returns, and then mixes random calls, returns, interrupts and low-byte writes over thousands of cycles. A behavioural model with a ring of eight slots and a modular index is compared against the block on every clock.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [2:0] {
    SRC_SEQ  = 3'd0,
    SRC_JUMP = 3'd1,
    SRC_CALL = 3'd2,
    SRC_RET  = 3'd3,
    SRC_INTR = 3'd4,
    SRC_HOLD = 3'd5
  } src_e;

  typedef struct packed {
    logic loadSeq;
    logic loadTarget;
    logic loadVector;
    logic loadStack;
    logic loadLow;
    logic push;
    logic pushCurrent;
    logic pop;
  } strobe_t;
endpackage

// File: rtl/pcs_ctrl.sv
module pcs_ctrl
  import pcs_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   srcSel,
  input  logic         lowWrEn,
  output strobe_t      strb
);
  always_comb begin
    strb = '0;
    if (lowWrEn) begin
      strb.loadLow = 1'b1;
    end else begin
      case (srcSel)
        SRC_SEQ:  strb.loadSeq = 1'b1;
        SRC_JUMP: strb.loadTarget = 1'b1;
        SRC_CALL: begin
          strb.loadTarget = 1'b1;
          strb.push = 1'b1;
        end
        SRC_RET: begin
          strb.loadStack = 1'b1;
          strb.pop = 1'b1;
        end
        SRC_INTR: begin
          strb.loadVector = 1'b1;
          strb.push = 1'b1;
          strb.pushCurrent = 1'b1;
        end
        default: strb = '0;
      endcase
    end
  end

  assert_one_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.loadSeq, strb.loadTarget, strb.loadVector, strb.loadStack, strb.loadLow}));
  assert_hold_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (srcSel >= 3'd5 && !lowWrEn) |-> (strb == '0));
  assert_low_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lowWrEn |-> (!strb.push && !strb.pop));
endmodule

// File: rtl/pcs_stack.sv
module pcs_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] pushData,
  output logic [W-1:0] topData
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] ptr;
  logic [PW-1:0] ptrDec;

  // Circular index: relies on DEPTH being a power of two.
  assign ptrDec  = ptr - PW'(1);
  assign topData = slots[ptrDec];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
    end else if (push) begin
      slots[ptr] <= pushData;
      ptr <= ptr + PW'(1);
    end else if (pop) begin
      ptr <= ptrDec;
    end
  end

  assert_no_push_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));
  assert_push_stores_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (topData == $past(pushData)));
  assert_pop_wraps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> (ptr == $past(ptr) - PW'(1)));
endmodule

// File: rtl/pcs_datapath.sv
module pcs_datapath
  import pcs_pkg::*;
#(
  parameter int          PC_W      = 13,
  parameter int          LOW_W     = 8,
  parameter int          DEPTH     = 8,
  parameter logic [12:0] RESET_VEC = 13'h0000,
  parameter logic [12:0] INTR_VEC  = 13'h0004
) (
  input  logic               clk,
  input  logic               rst_n,
  input  strobe_t            strb,
  input  logic [PC_W-1:0]    jumpTarget,
  input  logic [LOW_W-1:0]   lowWrData,
  input  logic               pageWrEn,
  input  logic [PC_W-LOW_W-1:0] pageWrData,
  output logic [PC_W-1:0]    pc
);
  localparam int PG_W = PC_W - LOW_W;

  logic [PG_W-1:0] page;
  logic [PC_W-1:0] pcNext;
  logic [PC_W-1:0] pcInc;
  logic [PC_W-1:0] pushData;
  logic [PC_W-1:0] topData;

  assign pcInc    = pc + PC_W'(1);
  assign pushData = strb.pushCurrent ? pc : pcInc;

  pcs_stack #(.DEPTH(DEPTH), .W(PC_W)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (strb.push),
    .pop      (strb.pop),
    .pushData (pushData),
    .topData  (topData)
  );

  always_comb begin
    pcNext = pc;
    if (strb.loadLow)         pcNext = {page, lowWrData};
    else if (strb.loadTarget) pcNext = jumpTarget;
    else if (strb.loadVector) pcNext = INTR_VEC[PC_W-1:0];
    else if (strb.loadStack)  pcNext = topData;
    else if (strb.loadSeq)    pcNext = pcInc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc   <= RESET_VEC[PC_W-1:0];
      page <= '0;
    end else begin
      pc <= pcNext;
      if (pageWrEn) page <= pageWrData;
    end
  end

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strb.loadSeq |=> (pc == $past(pc) + PC_W'(1)));
  assert_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strb.loadVector |=> (pc == INTR_VEC[PC_W-1:0]));
  assert_low_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strb.loadLow |=> (pc == {$past(page), $past(lowWrData)}));
  assert_page_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pageWrEn |=> $stable(page));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (strb == '0) |=> $stable(pc));
endmodule

// File: rtl/pc_stack_unit.sv
module pc_stack_unit
  import pcs_pkg::*;
#(
  parameter int PC_W    = 13,
  parameter int LOW_W   = 8,
  parameter int PHYS_AW = 10,
  parameter int DEPTH   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2:0]            srcSel,
  input  logic [PC_W-1:0]       jumpTarget,
  input  logic                  lowWrEn,
  input  logic [LOW_W-1:0]      lowWrData,
  input  logic                  pageWrEn,
  input  logic [PC_W-LOW_W-1:0] pageWrData,
  output logic [PC_W-1:0]       pcFull,
  output logic [LOW_W-1:0]      pcLow,
  output logic [PHYS_AW-1:0]    fetchAddr
);
  strobe_t strb;

  pcs_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .srcSel  (srcSel),
    .lowWrEn (lowWrEn),
    .strb    (strb)
  );

  pcs_datapath #(.PC_W(PC_W), .LOW_W(LOW_W), .DEPTH(DEPTH)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .jumpTarget (jumpTarget),
    .lowWrData  (lowWrData),
    .pageWrEn   (pageWrEn),
    .pageWrData (pageWrData),
    .pc         (pcFull)
  );

  assign pcLow     = pcFull[LOW_W-1:0];
  assign fetchAddr = pcFull[PHYS_AW-1:0];

  assert_reset_low_R1: assert property (@(posedge clk)
    !rst_n |-> (pcFull == '0));
endmodule

// File: tb/pc_stack_unit_tb.sv
module pc_stack_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  srcSel = 3'd5;
  logic [12:0] jumpTarget = '0;
  logic        lowWrEn = 1'b0;
  logic [7:0]  lowWrData = '0;
  logic        pageWrEn = 1'b0;
  logic [4:0]  pageWrData = '0;
  logic [12:0] pcFull;
  logic [7:0]  pcLow;
  logic [9:0]  fetchAddr;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  string tag = "R1";

  int mPc = 0;
  int mPage = 0;
  int mIdx = 0;
  int mRing [8];

  always #2 clk = ~clk;

  pc_stack_unit u_dut (
    .clk(clk), .rst_n(rst_n), .srcSel(srcSel), .jumpTarget(jumpTarget),
    .lowWrEn(lowWrEn), .lowWrData(lowWrData), .pageWrEn(pageWrEn),
    .pageWrData(pageWrData), .pcFull(pcFull), .pcLow(pcLow), .fetchAddr(fetchAddr)
  );

  initial foreach (mRing[i]) mRing[i] = 0;

  // Reference model: updated at each rising edge from the driven inputs.
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      mPc = 0; mPage = 0; mIdx = 0;
      foreach (mRing[i]) mRing[i] = 0;
    end else begin
      int nextPc;
      nextPc = mPc;
      if (lowWrEn) nextPc = mPage * 256 + lowWrData;
      else begin
        case (srcSel)
          3'd0: nextPc = (mPc + 1) % 8192;
          3'd1: nextPc = jumpTarget;
          3'd2: begin mRing[mIdx] = (mPc + 1) % 8192; mIdx = (mIdx + 1) % 8; nextPc = jumpTarget; end
          3'd3: begin mIdx = (mIdx + 7) % 8; nextPc = mRing[mIdx]; end
          3'd4: begin mRing[mIdx] = mPc; mIdx = (mIdx + 1) % 8; nextPc = 4; end
          default: nextPc = mPc;
        endcase
      end
      if (pageWrEn) mPage = pageWrData;
      mPc = nextPc;
    end
    if (cycles > 100000) begin
      mismatched++;
      $display("FAIL watchdog: actual cycles=%0d expected below 100000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  // Compare away from the active edge.
  always @(negedge clk) begin
    compared++;
    if (pcFull !== 13'(mPc) || fetchAddr !== 10'(mPc % 1024) || pcLow !== 8'(mPc % 256)) begin
      mismatched++;
      $display("FAIL %s: actual pc=%h fetch=%h low=%h expected pc=%h fetch=%h low=%h",
               tag, pcFull, fetchAddr, pcLow, 13'(mPc), 10'(mPc % 1024), 8'(mPc % 256));
    end
  end

  task automatic step(input logic [2:0] s, input logic [12:0] t = '0,
                      input logic lw = 1'b0, input logic [7:0] ld = '0,
                      input logic pw = 1'b0, input logic [4:0] pd = '0);
    @(negedge clk);
    srcSel = s; jumpTarget = t; lowWrEn = lw; lowWrData = ld;
    pageWrEn = pw; pageWrData = pd;
  endtask

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(3'd5);
    tag = "R2";
    repeat (20) step(3'd0);
    tag = "R3";
    step(3'd1, 13'h1FFD);
    tag = "R2";
    repeat (5) step(3'd0);
    tag = "R9";
    step(3'd1, 13'h0420);
    step(3'd1, 13'h1C20);
    step(3'd0);
    tag = "R4";
    for (int k = 0; k < 8; k++) begin
      step(3'd2, 13'(13'h0100 * (k + 1) + k));
      step(3'd0);
    end
    for (int k = 0; k < 8; k++) step(3'd3);
    tag = "R5";
    step(3'd1, 13'h0777);
    step(3'd4);
    step(3'd0);
    step(3'd3);
    tag = "R6";
    for (int k = 0; k < 10; k++) step(3'd2, 13'(13'h0200 + 3 * k));
    for (int k = 0; k < 10; k++) step(3'd3);
    tag = "R8";
    step(3'd5, '0, 1'b0, '0, 1'b1, 5'h15);
    step(3'd0, '0, 1'b1, 8'h3C);
    step(3'd0, '0, 1'b1, 8'h81, 1'b1, 5'h0A);
    step(3'd0, '0, 1'b1, 8'h82);
    tag = "R7";
    step(3'd2, 13'h0055, 1'b1, 8'hEE);
    step(3'd3, '0, 1'b1, 8'h10);
    step(3'd3);
    tag = "R10";
    step(3'd5); step(3'd6); step(3'd7);
    step(3'd0);
    tag = "MIX";
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = $urandom_range(0, 15);
      step(3'($urandom_range(0, 7)), 13'($urandom), r == 0, 8'($urandom),
           r == 1 || r == 0, 5'($urandom));
    end
    tag = "R1";
    @(negedge clk); rst_n = 1'b0;
    step(3'd0);
    step(3'd0);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule